// File: doc/BRIEF.md
# Overlap-Aware Harmonic Injection Window Scheduler

This block decides when a grid-tied inverter drives its small second-harmonic test current and how strong that current should be. A strobe marks each positive-going zero crossing of the grid voltage; the block counts these fundamental cycles and repeats a fixed schedule every `cfg_period` cycles. At the start of each repeat an injection window opens and stays open for a whole number of cycles. The window is long enough that, when `cfg_inv_count` inverters on one node run the same schedule without talking to each other, at least `cfg_overlap` of them inject at the same moment. Since every window opens on a positive zero crossing, all inverters share the harmonic's phase.

The block also computes the harmonic amplitude coefficient. In droop mode the rated coefficient is multiplied by nominal power and divided by measured power, so a unit running below its rating still injects the same absolute harmonic. A serial divider runs without stopping in the background. Its latest result is taken at each period start, together with every configuration value, so nothing changes in the middle of a window. A phase accumulator, restarted at each zero crossing and advanced on a sample tick, feeds a parabolic sine approximation that serves as the harmonic reference. The step size sets the reference frequency, and twice the fundamental is its intended setting.

All pins are plain levels or single-cycle strobes. No stream and no back-pressure exist: the outputs are valid every cycle, and a consumer samples them whenever it needs to.

Top module: `hinj_sched_top`

## Requirements
- R1: After reset, `inj_active`, `win_idx`, `coef_out` and `ref_out` are 0, and `inj_active` stays 0 until the first `zc_pulse`.
- R2: The first `zc_pulse` after reset sets `win_idx` to 0. Each later `zc_pulse` adds one to `win_idx`, and the pulse that arrives when `win_idx` equals period−1 returns it to 0. A `cfg_period` of 0 is treated as 1.
- R3: The window length T is the smallest whole count greater than P·(l−1)/N, which is floor(P·(l−1)/N)+1, limited to the range 1..P. Here P is the effective period, N is `cfg_inv_count` and l is `cfg_overlap`. An l of 0 or 1 gives T=1, and N=0 gives T=P.
- R4: `inj_active` is 1 exactly while `win_idx` < T, so every window opens on a zero-crossing strobe at `win_idx` 0.
- R5: All configuration inputs, including the chosen coefficient, are captured only at a period start: the first strobe after reset, or a strobe while `win_idx` equals period−1. Changes at other times have no effect until then.
- R6: With `cfg_droop_en` 0, `coef_out` takes the value of `cfg_k_rated` at each period start.
- R7: With `cfg_droop_en` 1 and the measured power valid, `coef_out` becomes floor(`cfg_k_rated`·`cfg_p_nom`/`p_meas`), capped at `cfg_coef_max`. The power inputs must be held for at least 2·(COEF_W+PWR_W+1) cycles before the period start.
- R8: With `cfg_droop_en` 1, `coef_out` becomes `cfg_coef_max` when `p_meas` is 0 or less than `cfg_p_floor`. A value equal to the floor is valid.
- R9: The reference phase is set to 0 on `zc_pulse` and otherwise grows by `ref_step` (modulo 2^PH_W) on `smp_tick`. The strobe wins if both arrive together. `ref_out` follows the phase with one register of delay.
- R10: With x the phase's lower PH_W−1 bits, the magnitude of `ref_out` is floor(x·(2^(PH_W−1)−x)/2^(2·PH_W−4−(SIN_W−1))), saturated to 2^(SIN_W−1)−1. The sign is negative when the phase MSB is 1. With the defaults, phase 0x2000 gives 1536 and 0x4000 gives 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_pulse | input | 1 | One-cycle strobe at each positive grid-voltage zero crossing |
| smp_tick | input | 1 | Advance strobe for the reference phase |
| cfg_period | input | CYC_W | Repeat period in fundamental cycles |
| cfg_inv_count | input | N_W | Number of inverters sharing the node |
| cfg_overlap | input | N_W | Required count of simultaneous injectors |
| cfg_droop_en | input | 1 | Scale coefficient by nominal/measured power |
| cfg_k_rated | input | COEF_W | Rated amplitude coefficient |
| cfg_p_nom | input | PWR_W | Nominal power |
| cfg_p_floor | input | PWR_W | Lowest measured power taken as valid |
| cfg_coef_max | input | COEF_W | Saturation value of the coefficient |
| p_meas | input | PWR_W | Measured power |
| ref_step | input | PH_W | Phase increment per sample tick |
| inj_active | output | 1 | Injection window open |
| win_idx | output | CYC_W | Cycle index within the current period |
| coef_out | output | COEF_W | Harmonic amplitude coefficient |
| ref_out | output | SIN_W | Signed harmonic reference sample |

## Verification
The bench builds the block with its defaults: an 8-bit cycle count, 5-bit inverter and overlap counts, 16-bit power and coefficient fields, a 16-bit phase and a 12-bit reference. With these values, short periods of 1 to 12 cycles reach every clamp of the window-length rule: N of 0, l of 0, a length that would exceed the period, and a period of 0. The 32-step divider is slow enough that holding the power inputs long enough before a period start actually matters. A phase step of one eighth of a turn lands on the peak of the parabola and on its saturation, so each octant of the reference can be checked against an exact value.

// File: rtl/hinj_pkg.sv
package hinj_pkg;
  typedef enum logic [0:0] {
    DV_LOAD = 1'b0,
    DV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/hinj_win_len.sv
module hinj_win_len #(
  parameter int CYC_W = 8,
  parameter int N_W   = 5
) (
  input  logic [CYC_W-1:0] period,
  input  logic [N_W-1:0]   inv_count,
  input  logic [N_W-1:0]   overlap,
  output logic [CYC_W-1:0] per_eff,
  output logic [CYC_W-1:0] tcc
);
  localparam int PROD_W = CYC_W + N_W;

  logic [N_W-1:0]    lm1;
  logic [PROD_W-1:0] prod, den, quo;
  logic [PROD_W:0]   cand;

  always_comb begin
    per_eff = (period == '0) ? CYC_W'(1) : period;
    lm1     = (overlap == '0) ? '0 : overlap - N_W'(1);
    prod    = PROD_W'(per_eff) * PROD_W'(lm1);
    den     = (inv_count == '0) ? PROD_W'(1) : PROD_W'(inv_count);
    quo     = prod / den;
    cand    = (PROD_W+1)'(quo) + (PROD_W+1)'(1);
    if (inv_count == '0)
      tcc = per_eff;
    else if (cand > (PROD_W+1)'(per_eff))
      tcc = per_eff;
    else
      tcc = cand[CYC_W-1:0];
  end
endmodule

// File: rtl/hinj_cycle_sched.sv
module hinj_cycle_sched #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic [CYC_W-1:0] per_new,
  input  logic [CYC_W-1:0] tcc_new,
  output logic             period_start,
  output logic             started,
  output logic [CYC_W-1:0] idx,
  output logic [CYC_W-1:0] per_cur,
  output logic             active
);
  logic [CYC_W-1:0] idx_q, per_q, tcc_q;
  logic             run_q;

  assign period_start = zc && (!run_q || (idx_q == per_q - CYC_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
      per_q <= CYC_W'(1);
      tcc_q <= CYC_W'(1);
    end else if (zc) begin
      if (period_start) begin
        run_q <= 1'b1;
        idx_q <= '0;
        per_q <= per_new;
        tcc_q <= tcc_new;
      end else begin
        idx_q <= idx_q + CYC_W'(1);
      end
    end
  end

  assign started = run_q;
  assign idx     = idx_q;
  assign per_cur = per_q;
  assign active  = run_q && (idx_q < tcc_q);
endmodule

// File: rtl/hinj_serial_div.sv
module hinj_serial_div
  import hinj_pkg::*;
#(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  input  logic             tag_in,
  output logic [NUM_W-1:0] quo,
  output logic             tag_out
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  div_state_e       st_q;
  logic [NUM_W-1:0] sh_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tag_q;
  logic [DEN_W:0]   trial, rem_nx;
  logic             ge;

  always_comb begin
    trial  = {rem_q, sh_q[NUM_W-1]};
    ge     = (trial >= {1'b0, den_q});
    rem_nx = ge ? (trial - {1'b0, den_q}) : trial;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= DV_LOAD;
      sh_q    <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      tag_q   <= 1'b0;
      quo     <= '0;
      tag_out <= 1'b0;
    end else if (st_q == DV_LOAD) begin
      sh_q  <= num;
      rem_q <= '0;
      den_q <= den;
      tag_q <= tag_in;
      cnt_q <= '0;
      st_q  <= DV_RUN;
    end else begin
      sh_q  <= {sh_q[NUM_W-2:0], ge};
      rem_q <= rem_nx[DEN_W-1:0];
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        quo     <= {sh_q[NUM_W-2:0], ge};
        tag_out <= tag_q;
        st_q    <= DV_LOAD;
      end
    end
  end
endmodule

// File: rtl/hinj_droop_amp.sv
module hinj_droop_amp #(
  parameter int COEF_W = 16,
  parameter int PWR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              droop_en,
  input  logic [COEF_W-1:0] k_rated,
  input  logic [PWR_W-1:0]  p_nom,
  input  logic [PWR_W-1:0]  p_floor,
  input  logic [COEF_W-1:0] coef_max,
  input  logic [PWR_W-1:0]  p_meas,
  output logic [COEF_W-1:0] coef
);
  localparam int Q_W = COEF_W + PWR_W;

  logic [Q_W-1:0]    num, quo;
  logic              low_pwr, low_q;
  logic [COEF_W-1:0] coef_nx;

  assign num     = Q_W'(k_rated) * Q_W'(p_nom);
  assign low_pwr = (p_meas == '0) || (p_meas < p_floor);

  hinj_serial_div #(.NUM_W(Q_W), .DEN_W(PWR_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .num     (num),
    .den     (p_meas),
    .tag_in  (low_pwr),
    .quo     (quo),
    .tag_out (low_q)
  );

  always_comb begin
    if (!droop_en)
      coef_nx = k_rated;
    else if (low_q || (quo > Q_W'(coef_max)))
      coef_nx = coef_max;
    else
      coef_nx = quo[COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      coef <= '0;
    else if (latch)
      coef <= coef_nx;
  end
endmodule

// File: rtl/hinj_ref_gen.sv
module hinj_ref_gen #(
  parameter int PH_W  = 16,
  parameter int SIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  input  logic             tick,
  input  logic [PH_W-1:0]  step,
  output logic [SIN_W-1:0] ref_o
);
  localparam int HALF_W = PH_W - 1;
  localparam int MAG_W  = SIN_W - 1;
  localparam int PRD_W  = 2 * HALF_W + 1;
  localparam int SHIFT  = 2 * PH_W - 4 - MAG_W;
  localparam logic [HALF_W:0]  HALF_ONE = {1'b1, {HALF_W{1'b0}}};
  localparam logic [PRD_W-1:0] MAG_MAX  = PRD_W'((1 << MAG_W) - 1);

  logic [PH_W-1:0]   phase_q;
  logic [HALF_W-1:0] x;
  logic [HALF_W:0]   y;
  logic [PRD_W-1:0]  prod, mag_full;
  logic [MAG_W-1:0]  mag;
  logic [SIN_W-1:0]  mag_s, ref_d;

  always_comb begin
    x        = phase_q[HALF_W-1:0];
    y        = HALF_ONE - {1'b0, x};
    prod     = PRD_W'(x) * PRD_W'(y);
    mag_full = prod >> SHIFT;
    mag      = (mag_full > MAG_MAX) ? {MAG_W{1'b1}} : mag_full[MAG_W-1:0];
    mag_s    = {1'b0, mag};
    ref_d    = phase_q[PH_W-1] ? (~mag_s + SIN_W'(1)) : mag_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      ref_o   <= '0;
    end else begin
      if (zc)
        phase_q <= '0;
      else if (tick)
        phase_q <= phase_q + step;
      ref_o <= ref_d;
    end
  end
endmodule

// File: rtl/hinj_sched_top.sv
module hinj_sched_top #(
  parameter int CYC_W  = 8,
  parameter int N_W    = 5,
  parameter int COEF_W = 16,
  parameter int PWR_W  = 16,
  parameter int PH_W   = 16,
  parameter int SIN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_pulse,
  input  logic              smp_tick,
  input  logic [CYC_W-1:0]  cfg_period,
  input  logic [N_W-1:0]    cfg_inv_count,
  input  logic [N_W-1:0]    cfg_overlap,
  input  logic              cfg_droop_en,
  input  logic [COEF_W-1:0] cfg_k_rated,
  input  logic [PWR_W-1:0]  cfg_p_nom,
  input  logic [PWR_W-1:0]  cfg_p_floor,
  input  logic [COEF_W-1:0] cfg_coef_max,
  input  logic [PWR_W-1:0]  p_meas,
  input  logic [PH_W-1:0]   ref_step,
  output logic              inj_active,
  output logic [CYC_W-1:0]  win_idx,
  output logic [COEF_W-1:0] coef_out,
  output logic [SIN_W-1:0]  ref_out
);
  logic [CYC_W-1:0] per_new, tcc_new, sched_per;
  logic             period_start, sched_started;

  hinj_win_len #(.CYC_W(CYC_W), .N_W(N_W)) u_len (
    .period    (cfg_period),
    .inv_count (cfg_inv_count),
    .overlap   (cfg_overlap),
    .per_eff   (per_new),
    .tcc       (tcc_new)
  );

  hinj_cycle_sched #(.CYC_W(CYC_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .zc           (zc_pulse),
    .per_new      (per_new),
    .tcc_new      (tcc_new),
    .period_start (period_start),
    .started      (sched_started),
    .idx          (win_idx),
    .per_cur      (sched_per),
    .active       (inj_active)
  );

  hinj_droop_amp #(.COEF_W(COEF_W), .PWR_W(PWR_W)) u_amp (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch    (period_start),
    .droop_en (cfg_droop_en),
    .k_rated  (cfg_k_rated),
    .p_nom    (cfg_p_nom),
    .p_floor  (cfg_p_floor),
    .coef_max (cfg_coef_max),
    .p_meas   (p_meas),
    .coef     (coef_out)
  );

  hinj_ref_gen #(.PH_W(PH_W), .SIN_W(SIN_W)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .zc    (zc_pulse),
    .tick  (smp_tick),
    .step  (ref_step),
    .ref_o (ref_out)
  );
endmodule

// File: rtl/hinj_sched_chk.sv
module hinj_sched_chk #(
  parameter int CYC_W  = 8,
  parameter int COEF_W = 16,
  parameter int SIN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              zc_pulse,
  input logic              period_start,
  input logic              started,
  input logic [CYC_W-1:0]  per_cur,
  input logic              inj_active,
  input logic [CYC_W-1:0]  win_idx,
  input logic [COEF_W-1:0] coef_out,
  input logic [SIN_W-1:0]  ref_out
);
  p_idle_until_zc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !inj_active);

  p_idx_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (win_idx < per_cur));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_pulse && !period_start) |=> (win_idx == CYC_W'($past(win_idx) + CYC_W'(1))));

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_pulse |=> $stable(win_idx));

  p_first_cycle_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (win_idx == '0)) |-> inj_active);

  p_open_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inj_active) |-> (win_idx == '0));

  p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(coef_out));

  p_ref_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> ##2 (ref_out == '0));
endmodule

bind hinj_sched_top hinj_sched_chk #(.CYC_W(CYC_W), .COEF_W(COEF_W), .SIN_W(SIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .zc_pulse     (zc_pulse),
  .period_start (period_start),
  .started      (sched_started),
  .per_cur      (sched_per),
  .inj_active   (inj_active),
  .win_idx      (win_idx),
  .coef_out     (coef_out),
  .ref_out      (ref_out)
);

// File: tb/hinj_sched_top_test.sv
module hinj_sched_top_test;
  localparam int CYC_W = 8, N_W = 5, COEF_W = 16, PWR_W = 16, PH_W = 16, SIN_W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, zc_pulse, smp_tick, cfg_droop_en, inj_active;
  logic [CYC_W-1:0]  cfg_period, win_idx;
  logic [N_W-1:0]    cfg_inv_count, cfg_overlap;
  logic [COEF_W-1:0] cfg_k_rated, cfg_coef_max, coef_out;
  logic [PWR_W-1:0]  cfg_p_nom, cfg_p_floor, p_meas;
  logic [PH_W-1:0]   ref_step;
  logic signed [SIN_W-1:0] ref_out;

  hinj_sched_top uut (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse), .smp_tick(smp_tick),
    .cfg_period(cfg_period), .cfg_inv_count(cfg_inv_count), .cfg_overlap(cfg_overlap),
    .cfg_droop_en(cfg_droop_en), .cfg_k_rated(cfg_k_rated), .cfg_p_nom(cfg_p_nom),
    .cfg_p_floor(cfg_p_floor), .cfg_coef_max(cfg_coef_max), .p_meas(p_meas),
    .ref_step(ref_step), .inj_active(inj_active), .win_idx(win_idx),
    .coef_out(coef_out), .ref_out(ref_out)
  );

  // {period, inverter count, overlap, expected window length}
  localparam logic [25:0] VEC [10] = '{
    {8'd10, 5'd4, 5'd1, 8'd1},
    {8'd10, 5'd4, 5'd2, 8'd3},
    {8'd10, 5'd4, 5'd3, 8'd6},
    {8'd10, 5'd4, 5'd4, 8'd8},
    {8'd10, 5'd4, 5'd0, 8'd1},
    {8'd10, 5'd2, 5'd5, 8'd10},
    {8'd12, 5'd5, 5'd3, 8'd5},
    {8'd10, 5'd0, 5'd2, 8'd10},
    {8'd1,  5'd4, 5'd4, 8'd1},
    {8'd0,  5'd3, 5'd2, 8'd1}
  };

  int n_chk = 0, n_err = 0;
  bit mstart = 0;
  int mcnt = 0, mper = 1, mtcc = 1, pend_per = 1, pend_tcc = 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit z, input bit t, output bit bnd);
    @(negedge clk); zc_pulse = z; smp_tick = t;
    @(negedge clk); zc_pulse = 0; smp_tick = 0;
    @(negedge clk);
    bnd = 0;
    if (z) begin
      bnd = !mstart || (mcnt == mper - 1);
      if (bnd) begin
        mstart = 1; mcnt = 0; mper = pend_per; mtcc = pend_tcc;
      end else mcnt++;
    end
  endtask

  task automatic zc_once();
    bit b;
    pulse(1, 0, b);
  endtask

  task automatic tick_n(input int n);
    bit b;
    for (int i = 0; i < n; i++) pulse(0, 1, b);
  endtask

  task automatic to_boundary();
    bit b;
    b = 0;
    for (int i = 0; i < 300 && !b; i++) pulse(1, 0, b);
  endtask

  task automatic win_check(input string tag);
    chk({tag, " index"}, int'(win_idx), mcnt);
    chk({tag, " active"}, int'(inj_active), (mstart && mcnt < mtcc) ? 1 : 0);
  endtask

  task automatic set_sched(input int p, input int n, input int l, input int exp);
    cfg_period = CYC_W'(p); cfg_inv_count = N_W'(n); cfg_overlap = N_W'(l);
    pend_per = (p == 0) ? 1 : p;
    pend_tcc = exp;
  endtask

  task automatic latch_new();
    repeat (100) @(negedge clk);
    to_boundary();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #600000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; zc_pulse = 0; smp_tick = 0; ref_step = '0;
    cfg_droop_en = 0; cfg_k_rated = 16'd328; cfg_p_nom = 16'd1000;
    cfg_p_floor = 16'd100; cfg_coef_max = 16'd4000; p_meas = 16'd1000;
    set_sched(10, 4, 2, 3);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state and idle before the first strobe
    chk("R1 inj_active", int'(inj_active), 0);
    chk("R1 win_idx", int'(win_idx), 0);
    chk("R1 coef_out", int'(coef_out), 0);
    chk("R1 ref_out", int'(ref_out), 0);

    // R2 R3 R4 window table
    foreach (VEC[i]) begin
      set_sched(int'(VEC[i][25:18]), int'(VEC[i][17:13]), int'(VEC[i][12:8]), int'(VEC[i][7:0]));
      to_boundary();
      for (int c = 0; c < mper; c++) begin
        win_check($sformatf("R2 R3 R4 vec%0d c%0d", i, c));
        if (c < mper - 1) zc_once();
      end
    end

    // R5 mid-period configuration change
    set_sched(10, 4, 2, 3);
    to_boundary();
    win_check("R5 start");
    zc_once();
    set_sched(6, 4, 4, 5);
    for (int c = 2; c < 10; c++) begin
      zc_once();
      win_check($sformatf("R5 old window c%0d", c));
      if (c == 3) chk("R5 old length kept", int'(inj_active), 0);
    end
    zc_once();
    for (int c = 0; c < 6; c++) begin
      win_check($sformatf("R5 new window c%0d", c));
      if (c == 4) chk("R5 new length", int'(inj_active), 1);
      zc_once();
    end
    chk("R2 wrap after new period", int'(win_idx), 0);

    // coefficient
    set_sched(2, 1, 1, 1);
    latch_new();
    chk("R6 droop off", int'(coef_out), 328);
    cfg_droop_en = 1; p_meas = 16'd500;
    latch_new();
    chk("R7 droop half power", int'(coef_out), 656);
    p_meas = 16'd100;
    latch_new();
    chk("R8 at floor valid", int'(coef_out), 3280);
    p_meas = 16'd500;
    repeat (100) @(negedge clk);
    zc_once();
    chk("R5 coef held mid-window", int'(coef_out), 3280);
    latch_new();
    chk("R7 after boundary", int'(coef_out), 656);
    p_meas = 16'd99;
    latch_new();
    chk("R8 below floor", int'(coef_out), 4000);
    cfg_p_floor = 16'd0; p_meas = 16'd0;
    latch_new();
    chk("R8 zero power", int'(coef_out), 4000);
    cfg_p_floor = 16'd100; p_meas = 16'd100; cfg_coef_max = 16'd2000;
    latch_new();
    chk("R7 capped", int'(coef_out), 2000);
    cfg_droop_en = 0;
    latch_new();
    chk("R6 droop off again", int'(coef_out), 328);

    // reference
    ref_step = 16'h2000;
    zc_once();
    chk("R9 restart", int'(ref_out), 0);
    tick_n(2); @(negedge clk);
    chk("R10 quarter", int'(ref_out), 2047);
    tick_n(1); @(negedge clk);
    chk("R10 three eighths", int'(ref_out), 1536);
    tick_n(2); @(negedge clk);
    chk("R10 five eighths", int'(ref_out), -1536);
    tick_n(1); @(negedge clk);
    chk("R10 three quarters", int'(ref_out), -2047);
    tick_n(2); @(negedge clk);
    chk("R10 wrap", int'(ref_out), 0);
    tick_n(1); @(negedge clk);
    chk("R10 eighth", int'(ref_out), 1536);
    begin
      bit b;
      pulse(1, 1, b);
    end
    chk("R9 strobe wins over tick", int'(ref_out), 0);

    finish_run();
  end
endmodule